// File: doc/BRIEF.md
# Optical Pulse Sensor Four-Phase Timing Controller

This block drives the per-period timing of a dual-LED optical pulse front end. It counts a 1 MHz tick enable and splits each pulse period into four sample windows of equal length. The windows run in a fixed order: LED1 lit, first ambient, LED2 lit, second ambient. As each window closes, the block issues a one-tick ADC reset and then a one-tick conversion start for that window. The conversions therefore run pipelined behind the sampling.

Software sets three values through a simple write port: the period register, the window length (the LED on-time) and a mode bit. Out-of-range values are clamped. A new setting is copied into working registers only at a period boundary, so a running window is never cut short. When the mode bit is set, a power-down output gates the front end and the ADC in two cases: while the sequence is idle, and in the quiet tail of each period after the last conversion.

Top module: `ppg_phase_timer`

## Requirements
- R1: After reset all strobe outputs, both LED enables and the power-down output are low, and the sequence is idle.
- R2: A running period lasts P+1 ticks, where P is the period register (address 0) clamped to the range 244..15624. This keeps the pulse rate between 64 Hz and 4096 Hz.
- R3: The window length W is the on-time register (address 1) clamped to the range 50..(P-1)>>2.
- R4: With tick index c counted from 0 within the period, `sampleWin[k]` is high exactly for W*k <= c < W*(k+1). Bit 0 is LED1, bit 1 is ambient 1, bit 2 is LED2 and bit 3 is ambient 2. At most one bit is high at a time.
- R5: `led1En` follows window 0 and `led2En` follows window 2.
- R6: `adcRst` is high for the single tick c = W*(k+1), for each k from 0 to 3.
- R7: `convStart[k]` is high for the single tick c = W*(k+1)+1, the tick after that window's ADC reset.
- R8: With mode bit 0 (address 2) set, `fePwd` is high while idle and for c >= 4W+62 in a running period, and is low otherwise. With the bit clear, `fePwd` stays low.
- R9: A register write takes effect at the next period boundary. If the write lands on the same clock as the boundary, it is applied one period later. While idle, a write takes effect before the next start.
- R10: When `enable` is high, the first tick starts window 0 at c = 0. When `enable` drops, the current period runs to its end and then every strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-clock pulse per 1 us tick |
| enable | input | 1 | Run request |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | 0 period, 1 on-time, 2 mode |
| cfgData | input | 16 | Write data |
| sampleWin | output | 4 | Sample windows LED1, AMB1, LED2, AMB2 |
| convStart | output | 4 | Conversion start per window |
| adcRst | output | 1 | ADC reset pulse |
| led1En | output | 1 | LED1 drive enable |
| led2En | output | 1 | LED2 drive enable |
| fePwd | output | 1 | Front end and ADC power-down |

## Verification
A register write and a period-boundary reload of the working registers can fall in the same clock. The reload must take the old value, and the new value must appear one period later. The bench provokes this by holding the write until the tick that wraps the counter. It then measures the lengths of the next two periods from the LED1 window edges. A disable can also coincide with the tail of a period; it is judged by checking that the second ambient window of that period still occurs and that no LED1 window follows. A bench model recomputes every strobe on every clock from the requirement formulas.

// File: rtl/ppg_tc_pkg.sv
package ppg_tc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } runState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic run;      // sequence active
    logic advance;  // step the tick counter
    logic wrap;     // period boundary reached on this tick
    logic load;     // copy live config into the working set
  } ctlStrb_t;

endpackage

// File: rtl/ppg_phase_ctrl.sv
module ppg_phase_ctrl
  import ppg_tc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tickEn,
  input  logic     enable,
  input  logic     atEnd,
  output ctlStrb_t strb
);

  runState_t state, stateNxt;

  always_comb begin
    strb.run     = (state == ST_RUN);
    strb.advance = strb.run && tickEn && !atEnd;
    strb.wrap    = strb.run && tickEn && atEnd;
    strb.load    = !strb.run || (strb.wrap && enable);
    stateNxt     = state;
    if (state == ST_IDLE && tickEn && enable) stateNxt = ST_RUN;
    else if (strb.wrap && !enable)            stateNxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  // R10
  stop_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.run && !tickEn) |=> strb.run);

endmodule

// File: rtl/ppg_phase_dp.sv
module ppg_phase_dp
  import ppg_tc_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PER_MIN    = 244,
  parameter int PER_MAX    = 15624,
  parameter int MIN_WIN    = 50,
  parameter int CONV_TICKS = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  input  ctlStrb_t         strb,
  output logic             atEnd,
  output logic [3:0]       sampleWin,
  output logic [3:0]       convStart,
  output logic             adcRst,
  output logic             led1En,
  output logic             led2En,
  output logic             fePwd
);

  localparam int EW = CNT_W + 3;
  localparam logic [CNT_W-1:0] P_LO = CNT_W'(PER_MIN);
  localparam logic [CNT_W-1:0] P_HI = CNT_W'(PER_MAX);
  localparam logic [CNT_W-1:0] W_LO = CNT_W'(MIN_WIN);
  localparam logic [EW-1:0]    TAIL = EW'(CONV_TICKS + 2);

  logic [CNT_W-1:0] perReg, onReg, perEff, winMax, winEff;
  logic [CNT_W-1:0] perS, winS, cnt;
  logic             dpdReg, dpdS;

  // live registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perReg <= P_HI;
      onReg  <= W_LO;
      dpdReg <= 1'b0;
    end else if (cfgWe) begin
      case (cfgAddr)
        2'd0:    perReg <= cfgData;
        2'd1:    onReg  <= cfgData;
        2'd2:    dpdReg <= cfgData[0];
        default: ;
      endcase
    end
  end

  // clamping of live values
  always_comb begin
    perEff = (perReg < P_LO) ? P_LO : (perReg > P_HI) ? P_HI : perReg;
    winMax = (perEff - CNT_W'(1)) >> 2;
    winEff = (onReg < W_LO) ? W_LO : (onReg > winMax) ? winMax : onReg;
  end

  // working set, reloaded only at boundaries or while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perS <= P_HI;
      winS <= W_LO;
      dpdS <= 1'b0;
    end else if (strb.load) begin
      perS <= perEff;
      winS <= winEff;
      dpdS <= dpdReg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (strb.wrap)    cnt <= '0;
    else if (strb.advance) cnt <= cnt + CNT_W'(1);
  end

  assign atEnd = (cnt == perS);

  logic [EW-1:0] cntX, winX;
  logic [EW-1:0] bnd [0:4];
  logic [3:0]    rstHit;

  assign cntX = EW'(cnt);
  assign winX = EW'(winS);

  for (genvar g = 0; g <= 4; g++) begin : g_bnd
    localparam logic [EW-1:0] MUL = EW'(g);
    assign bnd[g] = winX * MUL;
  end

  for (genvar k = 0; k < 4; k++) begin : g_phase
    assign sampleWin[k] = strb.run && (cntX >= bnd[k]) && (cntX < bnd[k+1]);
    assign rstHit[k]    = (cntX == bnd[k+1]);
    assign convStart[k] = strb.run && (cntX == bnd[k+1] + EW'(1));
  end

  assign adcRst = strb.run && (|rstHit);
  assign led1En = sampleWin[0];
  assign led2En = sampleWin[2];
  assign fePwd  = dpdS && (!strb.run || (cntX >= bnd[4] + TAIL));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= perS);

  // R3
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (winS >= W_LO) && ((winX << 2) + EW'(2) <= EW'(perS) + EW'(1)));

  // R4
  win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sampleWin));

  // R7
  conv_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|convStart) |-> $past(adcRst));

  // R8
  pwd_led_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fePwd |-> (!led1En && !led2En));

  // R9
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.run && !strb.wrap) |=> $stable(perS) && $stable(winS));

endmodule

// File: rtl/ppg_phase_timer.sv
module ppg_phase_timer
  import ppg_tc_pkg::*;
#(
  parameter int TICK_HZ     = 1000000,
  parameter int MIN_RATE_HZ = 64,
  parameter int MAX_RATE_HZ = 4096,
  parameter int CNT_W       = 16,
  parameter int MIN_WIN     = 50,
  parameter int CONV_TICKS  = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             enable,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  output logic [3:0]       sampleWin,
  output logic [3:0]       convStart,
  output logic             adcRst,
  output logic             led1En,
  output logic             led2En,
  output logic             fePwd
);

  localparam int PER_MAX = TICK_HZ / MIN_RATE_HZ - 1;
  localparam int PER_MIN = (TICK_HZ + MAX_RATE_HZ - 1) / MAX_RATE_HZ - 1;

  ctlStrb_t strb;
  logic     atEnd;

  ppg_phase_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tickEn (tickEn),
    .enable (enable),
    .atEnd  (atEnd),
    .strb   (strb)
  );

  ppg_phase_dp #(
    .CNT_W      (CNT_W),
    .PER_MIN    (PER_MIN),
    .PER_MAX    (PER_MAX),
    .MIN_WIN    (MIN_WIN),
    .CONV_TICKS (CONV_TICKS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .strb      (strb),
    .atEnd     (atEnd),
    .sampleWin (sampleWin),
    .convStart (convStart),
    .adcRst    (adcRst),
    .led1En    (led1En),
    .led2En    (led2En),
    .fePwd     (fePwd)
  );

endmodule

// File: tb/ppg_phase_timer_tb.sv
module ppg_phase_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P_LO = 244;
  localparam int P_HI = 15624;
  localparam int W_LO = 50;
  localparam int CONV = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b0;
  logic        enable = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [15:0] cfgData = 16'd0;
  logic [3:0]  sampleWin, convStart;
  logic        adcRst, led1En, led2En, fePwd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model state
  int  mRun = 0, mCnt = 0, mPer = P_HI, mWin = W_LO, mDpd = 0;
  int  lPer = P_HI, lOn = W_LO, lDpd = 0;
  int  tickNo = 0;
  int  riseTick [4];
  bit  riseSeen [4];
  bit  prevS [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ppg_phase_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .enable(enable),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .sampleWin(sampleWin), .convStart(convStart), .adcRst(adcRst),
    .led1En(led1En), .led2En(led2En), .fePwd(fePwd)
  );

  function automatic int clampPer(int v);
    return (v < P_LO) ? P_LO : (v > P_HI) ? P_HI : v;
  endfunction

  function automatic int clampWin(int on, int pc);
    int mx = (pc - 1) >> 2;
    return (on < W_LO) ? W_LO : (on > mx) ? mx : on;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (tick %0d)", tag, act, exp, tickNo);
    end
  endtask

  // model update for one rising edge, from pre-edge values
  task automatic modelEdge(bit t);
    int nRun = mRun, nCnt = mCnt;
    bit load = (mRun == 0) || (t && mCnt == mPer && enable);
    if (mRun == 0) begin
      if (t && enable) nRun = 1;
    end else if (t) begin
      if (mCnt == mPer) begin
        nCnt = 0;
        if (!enable) nRun = 0;
      end else nCnt = mCnt + 1;
    end
    if (load) begin
      mPer = clampPer(lPer);
      mWin = clampWin(lOn, clampPer(lPer));
      mDpd = lDpd;
    end
    mRun = nRun;
    mCnt = nCnt;
    if (cfgWe) begin
      case (cfgAddr)
        2'd0: lPer = int'(cfgData);
        2'd1: lOn  = int'(cfgData);
        2'd2: lDpd = int'(cfgData[0]);
        default: ;
      endcase
    end
  endtask

  task automatic compareAll();
    int eS = 0, eC = 0, eR = 0, eP;
    for (int k = 0; k < 4; k++) begin
      if (mRun != 0 && mCnt >= k*mWin && mCnt < (k+1)*mWin) eS |= (1 << k);
      if (mRun != 0 && mCnt == (k+1)*mWin + 1) eC |= (1 << k);
    end
    if (mRun != 0 && mCnt >= mWin && mCnt <= 4*mWin && (mCnt % mWin) == 0) eR = 1;
    eP = (mDpd != 0 && (mRun == 0 || mCnt >= 4*mWin + 2 + CONV)) ? 1 : 0;
    chk("R4 windows", int'(sampleWin), eS);
    chk("R5 leds", int'({led2En, led1En}), ((eS >> 1) & 2) | (eS & 1));
    chk("R6 adcRst", int'(adcRst), eR);
    chk("R7 convStart", int'(convStart), eC);
    chk("R8 fePwd", int'(fePwd), eP);
    for (int k = 0; k < 4; k++) begin
      if (sampleWin[k] && !prevS[k]) begin
        riseTick[k] = tickNo;
        riseSeen[k] = 1;
      end
      prevS[k] = sampleWin[k];
    end
  endtask

  task automatic step(bit t);
    tickEn = t;
    @(posedge clk);
    if (t) tickNo++;
    modelEdge(t);
    @(negedge clk);
    compareAll();
    tickEn = 1'b0;
    cfgWe = 1'b0;
  endtask

  task automatic tickPair();
    step(1'b1);
    step(1'b0);
  endtask

  task automatic wr(logic [1:0] a, int d, bit t);
    cfgWe = 1'b1;
    cfgAddr = a;
    cfgData = 16'(d);
    step(t);
  endtask

  task automatic waitRise(int k);
    riseSeen[k] = 0;
    while (!riseSeen[k]) tickPair();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r0, r1, r2, w;
    int per, on;
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) begin
      riseTick[k] = 0;
      riseSeen[k] = 0;
      prevS[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0);
    // R1
    chk("R1 reset", int'({sampleWin, convStart, adcRst, led1En, led2En, fePwd}), 0);
    repeat (3) tickPair();
    chk("R1 idle", int'(sampleWin), 0);

    // clamping of low period and high on-time, idle power-down
    wr(2'd0, 10, 1'b0);
    wr(2'd1, 1000, 1'b0);
    wr(2'd2, 1, 1'b0);
    step(1'b0);
    chk("R8 idle pwd", int'(fePwd), 1);
    enable = 1'b1;
    step(1'b1);
    // R10 start in window 0 on first tick
    chk("R10 start", int'(sampleWin), 1);
    waitRise(0); r0 = riseTick[0];
    waitRise(0);
    chk("R2 low clamp period", riseTick[0] - r0, 245);
    r0 = riseTick[0];
    waitRise(1);
    chk("R3 window clamp", riseTick[1] - r0, 60);

    // R9 mid-period write waits for boundary
    waitRise(0); r0 = riseTick[0];
    repeat (20) tickPair();
    wr(2'd0, 400, 1'b0);
    waitRise(0); r1 = riseTick[0];
    chk("R9 old period kept", r1 - r0, 245);
    waitRise(0); r2 = riseTick[0];
    chk("R9 new period", r2 - r1, 401);

    // R9 write on the wrapping tick
    tickPair();
    while (mCnt != mPer) tickPair();
    wr(2'd0, 600, 1'b1);
    r0 = riseTick[0];
    chk("R9 wrap rise", r0, tickNo);
    waitRise(0); r1 = riseTick[0];
    chk("R9 coincident write deferred", r1 - r0, 401);
    waitRise(0); r2 = riseTick[0];
    chk("R9 coincident write applied", r2 - r1, 601);

    // R10 disable mid-period
    repeat (100) tickPair();
    enable = 1'b0;
    repeat (1300) tickPair();
    chk("R10 no new period", riseTick[0], r2);
    chk("R10 period finished", (riseTick[3] > r2) ? 1 : 0, 1);
    chk("R10 strobes low", int'({sampleWin, convStart, adcRst, led1En, led2En}), 0);

    // random rounds
    for (int i = 0; i < 10; i++) begin
      per = $urandom_range(150, 900);
      on  = $urandom_range(0, 450);
      wr(2'd0, per, 1'b0);
      wr(2'd1, on, 1'b0);
      wr(2'd2, $urandom_range(0, 1), 1'b0);
      enable = 1'b1;
      repeat (2 * (clampPer(per) + 1) + 10) tickPair();
      if ($urandom_range(0, 1) == 1) begin
        enable = 1'b0;
        repeat (clampPer(per) + 5) tickPair();
      end
    end

    // R2 high clamp
    enable = 1'b0;
    while (mRun != 0) tickPair();
    wr(2'd0, 60000, 1'b0);
    wr(2'd1, 7000, 1'b0);
    enable = 1'b1;
    waitRise(0); r0 = riseTick[0];
    waitRise(0);
    chk("R2 high clamp period", riseTick[0] - r0, 15625);
    w = clampWin(7000, P_HI);
    chk("R3 high clamp window", w, 3905);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule